// File: doc/BRIEF.md
# Strobe-Latched One-Time-Programmable Read Port

This block models a 512-word by 8-bit fuse memory behind a strobe-driven read interface, written for a clocked FPGA fabric. An active-low select strobe is sampled on the system clock. The cycle in which the strobe is first seen low captures the address. The addressed word then flows into an output register, which keeps tracking the array for as long as the strobe stays low. Once the strobe returns high, the output register freezes and ignores both the address pins and any change to the array.

Three output-enable pins combine into a single bus-drive flag: two are active high and one is active low. This flag does not depend on the strobe. The data word and the drive flag are separate outputs, so a high-impedance bus is represented by the flag being low.

After reset, the block spends DEPTH cycles writing zero to every location. Programming then becomes available. Each program request, accepted only while the program-enable pin is high, sets exactly one bit of the word at the latched address. No operation ever clears a bit.

Top module: `prom_strobe_read`

## Requirements
- R1: During reset, and in the first cycle after it, q_o is 0 and q_oe_o is 0. After the clear sweep, which takes DEPTH cycles from reset release, every one of the 512 locations reads 0.
- R2: The address is captured only in a clock cycle where sel_n_i is sampled low after having been high in the previous cycle. Address changes while the strobe stays low have no effect on the word presented.
- R3: While sel_n_i stays low, q_o shows the word at the latched address no more than three clock edges after the capture edge. It also follows later programming of that word within three edges.
- R4: While sel_n_i is high, q_o holds its last value. This holds even when the address pins change or the word at the latched address is programmed.
- R5: q_oe_o equals oe_a_i AND oe_b_i AND NOT oe_c_n_i, registered one clock later, whatever the strobe is doing.
- R6: A cycle with prog_en_i=1 and prog_req_i=1 sets bit prog_bit_i (0 is the LSB, binary index) of the word at the latched address. All other bits and all other words are unchanged.
- R7: Programming a bit that is already 1 leaves the word unchanged. No operation turns a 1 back into 0.
- R8: prog_req_i with prog_en_i=0 changes no stored bit.
- R9: Program requests made during the clear sweep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| addr_i | input | 9 | Word address, captured on the strobe falling edge |
| sel_n_i | input | 1 | Active-low select strobe |
| oe_a_i | input | 1 | Output enable, active high |
| oe_b_i | input | 1 | Output enable, active high |
| oe_c_n_i | input | 1 | Output enable, active low |
| prog_en_i | input | 1 | Program enable; low means read only |
| prog_req_i | input | 1 | One-cycle request to program one bit |
| prog_bit_i | input | 3 | Binary index of the bit to set |
| q_o | output | 8 | Output data register |
| q_oe_o | output | 1 | Bus drive flag (0 = high impedance) |

## Verification
All 512 words are first read back as zero after the sweep. Every word is then programmed with a pattern computed from its own address, and all 512 are read back. This separates address-decode faults from lane faults, because neighbouring words carry different bit mixes.

All eight combinations of the enable pins are applied. This shows whether the drive flag decodes each polarity correctly.

Directed sequences cover the remaining cases:
- changing the address while the strobe is low (tells capture-on-edge apart from a transparent address latch);
- programming while the strobe is low versus high (tells a tracking output from a frozen one);
- repeated and disabled program requests;
- requests made during the sweep.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int unsigned PROM_WORDS = 512;
  localparam int unsigned PROM_WIDTH = 8;
endpackage

// File: rtl/prom_strobe_edge.sv
module prom_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_i,
  output logic fall_o
);
  logic sel_n_d;

  always_ff @(posedge clk) begin
    if (rst) sel_n_d <= 1'b1;
    else     sel_n_d <= sel_n_i;
  end

  assign fall_o = sel_n_d & ~sel_n_i;
endmodule

// File: rtl/prom_fuse_array.sv
module prom_fuse_array #(
  parameter int unsigned DEPTH = prom_pkg::PROM_WORDS,
  parameter int unsigned WIDTH = prom_pkg::PROM_WIDTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr_i,
  input  logic          prog_en_i,
  input  logic          prog_req_i,
  input  logic [BW-1:0] prog_bit_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic          clearing;
  logic [AW-1:0] clr_cnt;
  logic          prog_ok;
  logic [AW-1:0] waddr;
  logic          wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_cnt  <= '0;
    end else if (clearing) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == AW'(DEPTH - 1)) clearing <= 1'b0;
    end
  end

  assign prog_ok = ~clearing & prog_en_i & prog_req_i;
  assign waddr   = clearing ? clr_cnt : raddr_i;
  assign wdata   = ~clearing;

  for (genvar l = 0; l < WIDTH; l++) begin : g_lane
    logic lane_mem [DEPTH];
    logic lane_we;
    assign lane_we = clearing | (prog_ok & (prog_bit_i == BW'(l)));
    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[waddr] <= wdata;
      rdata_o[l] <= lane_mem[raddr_i];
    end
  end

  assert_sweep_ends_R1: assert property (@(posedge clk) disable iff (rst)
    (clearing && clr_cnt == AW'(DEPTH - 1)) |=> !clearing);
  assert_sweep_once_R9: assert property (@(posedge clk) disable iff (rst)
    !clearing |=> !clearing);
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage #(
  parameter int unsigned WIDTH = prom_pkg::PROM_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             oe_a_i,
  input  logic             oe_b_i,
  input  logic             oe_c_n_i,
  output logic [WIDTH-1:0] q_o,
  output logic             q_oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o    <= '0;
      q_oe_o <= 1'b0;
    end else begin
      if (!sel_n_i) q_o <= word_i;
      q_oe_o <= oe_a_i & oe_b_i & ~oe_c_n_i;
    end
  end

  assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    sel_n_i |=> $stable(q_o));
  assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> q_oe_o == $past(oe_a_i & oe_b_i & ~oe_c_n_i));
endmodule

// File: rtl/prom_strobe_read.sv
module prom_strobe_read #(
  parameter int unsigned DEPTH = prom_pkg::PROM_WORDS,
  parameter int unsigned WIDTH = prom_pkg::PROM_WIDTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_i,
  input  logic             sel_n_i,
  input  logic             oe_a_i,
  input  logic             oe_b_i,
  input  logic             oe_c_n_i,
  input  logic             prog_en_i,
  input  logic             prog_req_i,
  input  logic [BW-1:0]    prog_bit_i,
  output logic [WIDTH-1:0] q_o,
  output logic             q_oe_o
);
  logic             fall;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] word;

  prom_strobe_edge u_edge (
    .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .fall_o(fall)
  );

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (fall) addr_q <= addr_i;
  end

  prom_fuse_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk(clk), .rst(rst), .raddr_i(addr_q),
    .prog_en_i(prog_en_i), .prog_req_i(prog_req_i), .prog_bit_i(prog_bit_i),
    .rdata_o(word)
  );

  prom_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .word_i(word),
    .oe_a_i(oe_a_i), .oe_b_i(oe_b_i), .oe_c_n_i(oe_c_n_i),
    .q_o(q_o), .q_oe_o(q_oe_o)
  );

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    fall |=> addr_q == $past(addr_i));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(addr_q));
endmodule

// File: tb/sim_prom_strobe_read.sv
`timescale 1ns/1ps
module sim_prom_strobe_read;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] addr = '0;
  logic sel_n = 1'b1;
  logic oe_a = 1'b0, oe_b = 1'b0, oe_c_n = 1'b1;
  logic prog_en = 1'b0, prog_req = 1'b0;
  logic [2:0] prog_bit = '0;
  logic [7:0] q;
  logic q_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [512];
  logic [7:0] v;

  always #2.5 clk = ~clk;

  prom_strobe_read u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .sel_n_i(sel_n),
    .oe_a_i(oe_a), .oe_b_i(oe_b), .oe_c_n_i(oe_c_n),
    .prog_en_i(prog_en), .prog_req_i(prog_req), .prog_bit_i(prog_bit),
    .q_o(q), .q_oe_o(q_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(((a * 7) ^ (a >> 2)) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic latch(input int a);
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk); addr = 9'(a); sel_n = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_word(input int a, output logic [7:0] r);
    latch(a);
    settle();
    r = q;
    sel_n = 1'b1;
  endtask

  task automatic pulse(input int b, input logic en);
    @(negedge clk); prog_en = en; prog_req = 1'b1; prog_bit = 3'(b);
    @(negedge clk); prog_en = 1'b0; prog_req = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset q", q, 8'h00);
    chk("R1 reset oe", {7'b0, q_oe}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset q", q, 8'h00);
    chk("R1 after reset oe", {7'b0, q_oe}, 8'h00);
    // R9: requests during the sweep must be ignored (latched address 0)
    pulse(0, 1'b1);
    pulse(5, 1'b1);
    repeat (520) @(posedge clk);
    for (int a = 0; a < 512; a++) begin
      read_word(a, v);
      if (a == 0) chk("R9 sweep request ignored", v, 8'h00);
      else        chk("R1 cleared word", v, 8'h00);
    end
    // R5: all enable combinations, with the strobe in both states
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      oe_a = c[0]; oe_b = c[1]; oe_c_n = c[2]; sel_n = c[3];
      @(negedge clk);
      chk("R5 enable decode", {7'b0, q_oe}, {7'b0, c[0] & c[1] & ~c[2]});
    end
    @(negedge clk); sel_n = 1'b1; oe_a = 1'b1; oe_b = 1'b1; oe_c_n = 1'b0;
    // R6: program every word with its pattern, then read all back
    for (int a = 0; a < 512; a++) begin
      latch(a);
      for (int b = 0; b < 8; b++)
        if (pat(a)[b]) pulse(b, 1'b1);
      exp_mem[a] = pat(a);
    end
    for (int a = 0; a < 512; a++) begin
      read_word(a, v);
      chk("R6 programmed word", v, exp_mem[a]);
    end
    // R7: re-program already set bits (word 3 pattern)
    latch(3);
    for (int b = 0; b < 8; b++) if (exp_mem[3][b]) pulse(b, 1'b1);
    read_word(3, v);
    chk("R7 reprogram no change", v, exp_mem[3]);
    // R8: requests with program enable low on clear bits of word 4
    latch(4);
    for (int b = 0; b < 8; b++) if (!exp_mem[4][b]) pulse(b, 1'b0);
    read_word(4, v);
    chk("R8 disabled request", v, exp_mem[4]);
    // R2: address moves while strobe stays low
    latch(10);
    @(negedge clk); addr = 9'd11;
    settle();
    chk("R2 address captured at fall", q, exp_mem[10]);
    // R3: program while strobe low, output tracks
    begin
      int b3;
      b3 = 0;
      for (int b = 7; b >= 0; b--) if (!exp_mem[10][b]) b3 = b;
      pulse(b3, 1'b1);
      exp_mem[10][b3] = 1'b1;
      settle();
      chk("R3 output tracks array", q, exp_mem[10]);
    end
    // R4: strobe high, address changes, word programmed: output holds
    begin
      logic [7:0] held;
      int b4;
      held = q;
      @(negedge clk); sel_n = 1'b1; addr = 9'd200;
      b4 = 0;
      for (int b = 7; b >= 0; b--) if (!exp_mem[10][b]) b4 = b;
      pulse(b4, 1'b1);
      exp_mem[10][b4] = 1'b1;
      settle();
      chk("R4 output holds", q, held);
      read_word(10, v);
      chk("R4 later read sees program", v, exp_mem[10]);
      read_word(200, v);
      chk("R6 neighbour untouched", v, exp_mem[200]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule